// File: doc/BRIEF.md
# Byte-Wide Configuration Download Host

This block loads a stream of bytes into a target device through the target's byte-wide slave configuration port. After a one-cycle `start` it pulls the target's active-low program line low for a set number of system clocks. It then waits for the target's INIT line to read low and then high. Once INIT is high it asserts the active-low select and the active-low write strobe and begins to clock bytes across, one per configuration clock.

The configuration clock is divided down from the system clock. Data and strobes change only while that clock is low, so they are stable at each rising edge, which is when the target captures the byte. The target may raise BUSY to refuse a byte, and the host then presents the same byte again. After the byte flagged as last has been taken, the host releases the select and gives a fixed number of start-up clocks. It reports success only if the target's DONE line has been seen high by then. The host consumes bytes through a valid/ready stream. When that stream has nothing to offer, the configuration clock stops.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `tgt_prog_n`, `tgt_cs_n` and `tgt_rdwr_n` are 1, `tgt_cclk` and `s_ready` are 0, and `st_active`, `st_ok`, `st_err` and `st_code` are 0.
- R2: A `start` pulse in the idle state drives `tgt_prog_n` low for exactly PROG_CYCLES system clocks, and `st_active` is high while the load runs.
- R3: `tgt_cs_n` and `tgt_rdwr_n` go low only after `tgt_init_n` has been seen low and then high after the program pulse. The select is never low while `tgt_prog_n` is low.
- R4: If INIT has not been seen to return high within INIT_TIMEOUT system clocks after the program pulse ends, the load ends with `st_err`=1 and `st_code`=1, and the select is never asserted.
- R5: Every byte accepted on the stream reaches the target exactly once and in order. The target takes a byte at a rising `tgt_cclk` edge while `tgt_cs_n`=0 and `tgt_rdwr_n`=0. `tgt_d` and `tgt_cs_n` do not change while `tgt_cclk` is high.
- R6: With BUSY_CHECK=1, when `tgt_busy` is high at the falling half that follows a write edge, the same byte is presented for another configuration clock. No byte is lost or repeated beyond the refused edges.
- R7: With BUSY_CHECK=0, `tgt_busy` is ignored and each byte gets exactly one write edge.
- R8: While the input stream has no byte to offer during streaming, `tgt_cclk` makes no rising edge and the select stays asserted.
- R9: The byte that arrives with `s_last`=1 is the final one written. After it, exactly STARTUP_CLKS rising edges are given with `tgt_cs_n`=1, and then, if DONE was seen high, `st_ok`=1 and `st_code`=0.
- R10: If DONE has not been seen high by the end of the start-up clocks, the load ends with `st_err`=1 and `st_code`=3.
- R11: If INIT reads low during streaming or start-up, the load ends with `st_err`=1 and `st_code`=2, with `tgt_cs_n`=1 and `s_ready`=0.
- R12: `st_ok` and `st_err` hold until the next `start`. That `start` returns the block to idle with all flags clear and the program line high. A further `start` begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (idle), or return to idle (ok/error) |
| s_data | input | DATA_W | Stream byte |
| s_valid | input | 1 | Stream byte is valid |
| s_last | input | 1 | Stream byte is the final one |
| s_ready | output | 1 | Host accepts the stream byte this cycle |
| tgt_prog_n | output | 1 | Active-low program pulse to target |
| tgt_init_n | input | 1 | Target INIT line (high = ready, low = error) |
| tgt_done | input | 1 | Target DONE line |
| tgt_busy | input | 1 | Target BUSY line |
| tgt_cs_n | output | 1 | Active-low select |
| tgt_rdwr_n | output | 1 | Active-low write strobe |
| tgt_cclk | output | 1 | Configuration clock |
| tgt_d | output | DATA_W | Configuration data |
| st_active | output | 1 | Load in progress |
| st_ok | output | 1 | Load finished with DONE seen |
| st_err | output | 1 | Load finished in error |
| st_code | output | 2 | 0 none, 1 INIT timeout, 2 INIT lost, 3 DONE timeout |

## Verification
A randomly refusing target checks BUSY retries. A design that advanced on a refused edge would drop bytes, and one that misread the retry would duplicate them. Either shows up as a mismatch between the captured sequence and the sent one, or as a write-edge count other than bytes plus refusals. A long gap in the input stream checks that the clock stops. A design that kept clocking would write stale data as extra edges. A run with the busy check disabled and BUSY stuck high checks that a design which still obeyed BUSY would never finish. The three error exits (INIT stuck low, DONE never rising, INIT falling mid-stream) check that the error code and the released select are correct. A wrong start-up edge count or a missed last byte shows up in the edge totals.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_STREAM,
    ST_STARTUP,
    ST_OK,
    ST_ERR
  } ldr_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INIT_TMO  = 2'd1,
    ERR_INIT_LOST = 2'd2,
    ERR_DONE_TMO  = 2'd3
  } ldr_err_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic cclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  always_comb begin
    at_end    = (cnt == LAST);
    rise_tick = !cclk && run && at_end;
    fall_tick = cclk && at_end;
  end

  // Low phase counter saturates so a paused clock rises as soon as run returns
  always_ff @(posedge clk) begin
    if (rst) begin
      cclk <= 1'b0;
      cnt  <= '0;
    end else if (rise_tick || fall_tick) begin
      cclk <= ~cclk;
      cnt  <= '0;
    end else if (!at_end) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int INIT_TIMEOUT = 64,
  parameter int STARTUP_CLKS = 16,
  parameter bit BUSY_CHECK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              init_s,
  input  logic              done_s,
  input  logic              busy_s,
  input  logic              cclk_q,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              run,
  output logic              prog_n,
  output logic              cs_n,
  output logic              rdwr_n,
  output logic [DATA_W-1:0] dout,
  output logic              st_active,
  output logic              st_ok,
  output logic              st_err,
  output logic [1:0]        st_code
);
  localparam int TMAX = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int SW   = $clog2(STARTUP_CLKS + 1);
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_CYCLES - 1);
  localparam logic [TW-1:0] INIT_LAST = TW'(INIT_TIMEOUT - 1);
  localparam logic [SW-1:0] SU_LAST   = SW'(STARTUP_CLKS);

  ldr_state_e    state;
  logic [TW-1:0] tmr;
  logic [SW-1:0] su_cnt;
  logic          low_seen;
  logic          done_seen;
  logic          loaded;
  logic          last_q;
  logic          hold;

  always_comb begin
    hold    = BUSY_CHECK && busy_s;
    s_ready = (state == ST_STREAM) && !cclk_q && !loaded && !done_seen && init_s;
    run     = ((state == ST_STREAM) && loaded) ||
              ((state == ST_STARTUP) && (su_cnt != SU_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      su_cnt    <= '0;
      low_seen  <= 1'b0;
      done_seen <= 1'b0;
      loaded    <= 1'b0;
      last_q    <= 1'b0;
      prog_n    <= 1'b1;
      cs_n      <= 1'b1;
      rdwr_n    <= 1'b1;
      dout      <= '0;
      st_active <= 1'b0;
      st_ok     <= 1'b0;
      st_err    <= 1'b0;
      st_code   <= ERR_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_PROG;
            tmr       <= '0;
            prog_n    <= 1'b0;
            low_seen  <= 1'b0;
            done_seen <= 1'b0;
            loaded    <= 1'b0;
            last_q    <= 1'b0;
            st_active <= 1'b1;
          end
        end

        ST_PROG: begin
          if (!init_s) low_seen <= 1'b1;
          if (tmr == PROG_LAST) begin
            prog_n <= 1'b1;
            tmr    <= '0;
            state  <= ST_WAIT_INIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end

        ST_WAIT_INIT: begin
          if (!init_s) low_seen <= 1'b1;
          if (low_seen && init_s) begin
            state  <= ST_STREAM;
            cs_n   <= 1'b0;
            rdwr_n <= 1'b0;
          end else if (tmr == INIT_LAST) begin
            state     <= ST_ERR;
            st_active <= 1'b0;
            st_err    <= 1'b1;
            st_code   <= ERR_INIT_TMO;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end

        ST_STREAM: begin
          if (done_s) done_seen <= 1'b1;
          if (!init_s) begin
            state     <= ST_ERR;
            cs_n      <= 1'b1;
            rdwr_n    <= 1'b1;
            loaded    <= 1'b0;
            st_active <= 1'b0;
            st_err    <= 1'b1;
            st_code   <= ERR_INIT_LOST;
          end else if (fall_tick) begin
            if (!hold) begin
              loaded <= 1'b0;
              if (last_q) begin
                cs_n   <= 1'b1;
                rdwr_n <= 1'b1;
                su_cnt <= '0;
                state  <= ST_STARTUP;
              end
            end
          end else if (done_seen && !cclk_q) begin
            loaded <= 1'b0;
            cs_n   <= 1'b1;
            rdwr_n <= 1'b1;
            su_cnt <= '0;
            state  <= ST_STARTUP;
          end else if (s_valid && s_ready) begin
            dout   <= s_data;
            loaded <= 1'b1;
            last_q <= s_last;
          end
        end

        ST_STARTUP: begin
          if (done_s) done_seen <= 1'b1;
          if (!init_s) begin
            state     <= ST_ERR;
            st_active <= 1'b0;
            st_err    <= 1'b1;
            st_code   <= ERR_INIT_LOST;
          end else if (rise_tick) begin
            su_cnt <= su_cnt + 1'b1;
          end else if (fall_tick && (su_cnt == SU_LAST)) begin
            st_active <= 1'b0;
            if (done_seen || done_s) begin
              state <= ST_OK;
              st_ok <= 1'b1;
            end else begin
              state   <= ST_ERR;
              st_err  <= 1'b1;
              st_code <= ERR_DONE_TMO;
            end
          end
        end

        ST_OK, ST_ERR: begin
          if (start) begin
            state   <= ST_IDLE;
            st_ok   <= 1'b0;
            st_err  <= 1'b0;
            st_code <= ERR_NONE;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DATA_W       = 8,
  parameter int CCLK_HALF    = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int INIT_TIMEOUT = 64,
  parameter int STARTUP_CLKS = 16,
  parameter bit BUSY_CHECK   = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tgt_prog_n,
  input  logic              tgt_init_n,
  input  logic              tgt_done,
  input  logic              tgt_busy,
  output logic              tgt_cs_n,
  output logic              tgt_rdwr_n,
  output logic              tgt_cclk,
  output logic [DATA_W-1:0] tgt_d,
  output logic              st_active,
  output logic              st_ok,
  output logic              st_err,
  output logic [1:0]        st_code
);
  logic [2:0] sync_q;
  logic       run, rise_tick, fall_tick;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tgt_busy, tgt_done, tgt_init_n}),
    .q   (sync_q)
  );

  cfg_cclk_gen #(.DIV_HALF(CCLK_HALF)) u_cclk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cclk      (tgt_cclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  cfg_seq #(
    .DATA_W       (DATA_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .INIT_TIMEOUT (INIT_TIMEOUT),
    .STARTUP_CLKS (STARTUP_CLKS),
    .BUSY_CHECK   (BUSY_CHECK)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .init_s    (sync_q[0]),
    .done_s    (sync_q[1]),
    .busy_s    (sync_q[2]),
    .cclk_q    (tgt_cclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .run       (run),
    .prog_n    (tgt_prog_n),
    .cs_n      (tgt_cs_n),
    .rdwr_n    (tgt_rdwr_n),
    .dout      (tgt_d),
    .st_active (st_active),
    .st_ok     (st_ok),
    .st_err    (st_err),
    .st_code   (st_code)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              s_ready,
  input logic              tgt_prog_n,
  input logic              tgt_cs_n,
  input logic              tgt_cclk,
  input logic [DATA_W-1:0] tgt_d,
  input logic              st_active,
  input logic              st_ok,
  input logic              st_err,
  input logic [1:0]        st_code
);
  // R3
  cs_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_cs_n |-> tgt_prog_n);

  // R2
  prog_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_prog_n |-> st_active);

  // R5
  stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_cclk && !st_err) |-> ($stable(tgt_d) && $stable(tgt_cs_n)));

  // R8
  accept_low_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (!tgt_cclk && !tgt_cs_n));

  // R12
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_ok && st_err));

  // R10
  err_code_chk: assert property (@(posedge clk) disable iff (rst)
    st_err |-> (st_code != 2'd0));

  // R9
  ok_code_chk: assert property (@(posedge clk) disable iff (rst)
    !st_err |-> (st_code == 2'd0));

  // R11
  err_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_err) |-> (tgt_cs_n && !s_ready));
endmodule

bind cfg_loader cfg_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .s_ready    (s_ready),
  .tgt_prog_n (tgt_prog_n),
  .tgt_cs_n   (tgt_cs_n),
  .tgt_cclk   (tgt_cclk),
  .tgt_d      (tgt_d),
  .st_active  (st_active),
  .st_ok      (st_ok),
  .st_err     (st_err),
  .st_code    (st_code)
);

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  localparam int PROG_C = 8;
  localparam int SU_C   = 16;
  localparam int INIT_D = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       start = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic       tgt_prog_n, tgt_init_n, tgt_cs_n, tgt_rdwr_n, tgt_cclk;
  logic       tgt_done, tgt_busy;
  logic [7:0] tgt_d;
  logic       st_active, st_ok, st_err;
  logic [1:0] st_code;

  cfg_loader #(.STARTUP_CLKS(SU_C), .PROG_CYCLES(PROG_C)) dut_i (
    .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .tgt_prog_n(tgt_prog_n),
    .tgt_init_n(tgt_init_n), .tgt_done(tgt_done), .tgt_busy(tgt_busy),
    .tgt_cs_n(tgt_cs_n), .tgt_rdwr_n(tgt_rdwr_n), .tgt_cclk(tgt_cclk),
    .tgt_d(tgt_d), .st_active(st_active), .st_ok(st_ok), .st_err(st_err),
    .st_code(st_code));

  // second instance with the busy check disabled
  logic       nb_start = 1'b0, nb_s_ready, nb_prog_n, nb_init_n, nb_cs_n, nb_rdwr_n, nb_cclk;
  logic       nb_done, nb_active, nb_ok, nb_err;
  logic [1:0] nb_code;
  logic [7:0] nb_d;
  logic [2:0] nb_idx;
  int         nb_init_cnt;

  cfg_loader #(.STARTUP_CLKS(SU_C), .BUSY_CHECK(1'b0)) dut_nb_i (
    .clk(clk), .rst(rst), .start(nb_start), .s_data(8'hA0 + 8'(nb_idx)),
    .s_valid(nb_idx < 3'd4), .s_last(nb_idx == 3'd3), .s_ready(nb_s_ready),
    .tgt_prog_n(nb_prog_n), .tgt_init_n(nb_init_n), .tgt_done(nb_done),
    .tgt_busy(1'b1), .tgt_cs_n(nb_cs_n), .tgt_rdwr_n(nb_rdwr_n),
    .tgt_cclk(nb_cclk), .tgt_d(nb_d), .st_active(nb_active), .st_ok(nb_ok),
    .st_err(nb_err), .st_code(nb_code));

  // ---------------- target models ----------------
  bit   init_hold = 1'b0, init_force = 1'b0, busy_en = 1'b0, done_en = 1'b1;
  int   done_after = 0;
  int   init_cnt, prog_w, wr_n, rx_n, busy_n, su_n, rise_n;
  bit   cs_seen, cs_bad;
  logic cclk_d, prog_d, cs_d, nb_cclk_d;
  logic [7:0] rx [0:63];
  int   nb_wr;
  logic [7:0] nb_rx [0:7];

  assign tgt_init_n = !init_hold && !init_force && tgt_prog_n && (init_cnt >= INIT_D);
  assign nb_init_n  = nb_prog_n && (nb_init_cnt >= INIT_D);

  always @(posedge clk) begin
    if (rst) begin
      tgt_busy <= 1'b0; tgt_done <= 1'b0; init_cnt <= 0;
      cclk_d <= 1'b0; prog_d <= 1'b1; cs_d <= 1'b1;
      prog_w = 0; wr_n = 0; rx_n = 0; busy_n = 0; su_n = 0; rise_n = 0;
      cs_seen = 1'b0; cs_bad = 1'b0;
    end else begin
      cclk_d <= tgt_cclk; prog_d <= tgt_prog_n; cs_d <= tgt_cs_n;
      if (!tgt_prog_n) init_cnt <= 0;
      else if (init_cnt < 1000) init_cnt <= init_cnt + 1;
      if (!tgt_prog_n) begin
        if (prog_d) begin
          prog_w = 0; wr_n = 0; rx_n = 0; busy_n = 0; su_n = 0;
          cs_seen = 1'b0; cs_bad = 1'b0;
          tgt_done <= 1'b0; tgt_busy <= 1'b0;
        end
        prog_w++;
      end
      if (!tgt_cs_n) cs_seen = 1'b1;
      if (!tgt_cs_n && cs_d && !tgt_init_n) cs_bad = 1'b1;
      if (tgt_cclk && !cclk_d) begin
        rise_n++;
        if (!tgt_cs_n && !tgt_rdwr_n) begin
          wr_n++;
          if (busy_en && ($urandom_range(3) == 0)) begin
            tgt_busy <= 1'b1; busy_n++;
          end else begin
            tgt_busy <= 1'b0;
            if (rx_n < 64) rx[rx_n] = tgt_d;
            rx_n++;
            if (done_en && rx_n == done_after) tgt_done <= 1'b1;
          end
        end else if (tgt_cs_n) su_n++;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      nb_idx <= 3'd0; nb_init_cnt <= 0; nb_done <= 1'b0; nb_cclk_d <= 1'b0; nb_wr = 0;
    end else begin
      nb_cclk_d <= nb_cclk;
      if (nb_s_ready && nb_idx < 3'd4) nb_idx <= nb_idx + 3'd1;
      if (!nb_prog_n) nb_init_cnt <= 0;
      else if (nb_init_cnt < 1000) nb_init_cnt <= nb_init_cnt + 1;
      if (nb_cclk && !nb_cclk_d && !nb_cs_n && !nb_rdwr_n) begin
        if (nb_wr < 8) nb_rx[nb_wr] = nb_d;
        nb_wr++;
        if (nb_wr == 4) nb_done <= 1'b1;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  logic [7:0] exp_b [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_writes(input int nbytes, input int refused);
    return nbytes + refused;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 6000; k++) begin
      if (st_ok || st_err) break;
      @(negedge clk);
    end
  endtask

  task automatic send(input int n, input int gap_at, input int gap_len, input bit kill);
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) begin
        s_valid = 1'b0;
        if (kill) begin
          repeat (60) @(negedge clk);
          init_force = 1'b1;
          repeat (gap_len - 60) @(negedge clk);
        end else begin
          int r0;
          repeat (30) @(negedge clk);
          r0 = rise_n;
          repeat (gap_len - 30) @(negedge clk);
          // R8: no clock edge while the stream is dry
          chk(rise_n == r0, "R8", "rises during gap", rise_n - r0, 0);
          chk(tgt_cs_n == 1'b0, "R8", "select during gap", int'(tgt_cs_n), 0);
        end
      end
      s_data = exp_b[i]; s_last = (i == n - 1); s_valid = 1'b1;
      while (!s_ready && !st_err) @(negedge clk);
      if (st_err) break;
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tgt_prog_n && tgt_cs_n && tgt_rdwr_n && !tgt_cclk && !s_ready, "R1",
        "target lines", {tgt_prog_n, tgt_cs_n, tgt_rdwr_n, tgt_cclk, s_ready}, 5'b11100);
    chk(!st_active && !st_ok && !st_err && st_code == 2'd0, "R1", "status",
        {st_active, st_ok, st_err, st_code}, 0);

    // Session 1: 40 random bytes, random busy, dry gap
    fill(40); busy_en = 1'b1; done_en = 1'b1; done_after = 40;
    pulse_start();
    chk(st_active == 1'b1, "R2", "active during load", int'(st_active), 1);
    send(40, 20, 120, 1'b0);
    wait_end();
    chk(prog_w == PROG_C, "R2", "program pulse width", prog_w, PROG_C);
    chk(!cs_bad, "R3", "select before INIT high", int'(cs_bad), 0);
    chk(rx_n == 40, "R9", "bytes written up to last", rx_n, 40);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) if (rx[i] != exp_b[i]) bad++;
      chk(bad == 0, "R5", "byte order mismatches", bad, 0);
    end
    chk(wr_n == exp_writes(40, busy_n), "R6", "write edges", wr_n, exp_writes(40, busy_n));
    chk(busy_n > 0, "R6", "refusals exercised", busy_n, 1);
    chk(su_n == SU_C, "R9", "start-up edges", su_n, SU_C);
    chk(st_ok && !st_err && st_code == 2'd0, "R9", "ok status",
        {st_ok, st_err, st_code}, 4'b1000);
    repeat (40) @(negedge clk);
    chk(st_ok == 1'b1, "R12", "ok held", int'(st_ok), 1);
    pulse_start();
    chk(!st_ok && !st_err && !st_active && tgt_prog_n, "R12", "back to idle",
        {st_ok, st_err, st_active, tgt_prog_n}, 4'b0001);

    // Session 2: INIT stuck low
    init_hold = 1'b1;
    pulse_start();
    wait_end();
    chk(st_err && st_code == 2'd1, "R4", "init timeout code", int'(st_code), 1);
    chk(!cs_seen, "R4", "select never asserted", int'(cs_seen), 0);
    pulse_start();
    init_hold = 1'b0;

    // Session 3: DONE never rises
    fill(8); busy_en = 1'b0; done_en = 1'b0;
    pulse_start();
    send(8, -1, 0, 1'b0);
    wait_end();
    chk(st_err && st_code == 2'd3, "R10", "done timeout code", int'(st_code), 3);
    chk(su_n == SU_C, "R10", "start-up edges before timeout", su_n, SU_C);
    chk(rx_n == 8, "R5", "bytes written", rx_n, 8);
    pulse_start();

    // Session 4: INIT falls mid-stream
    fill(12); busy_en = 1'b1; done_en = 1'b1; done_after = 12;
    pulse_start();
    send(12, 5, 120, 1'b1);
    wait_end();
    chk(st_err && st_code == 2'd2, "R11", "init lost code", int'(st_code), 2);
    chk(tgt_cs_n == 1'b1, "R11", "select released", int'(tgt_cs_n), 1);
    chk(s_ready == 1'b0, "R11", "stream halted", int'(s_ready), 0);
    pulse_start();
    init_force = 1'b0;
    chk(!st_err && st_code == 2'd0, "R12", "error cleared", int'(st_code), 0);

    // Session 5: busy check disabled, BUSY stuck high
    @(negedge clk) nb_start = 1'b1;
    @(negedge clk) nb_start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (nb_ok || nb_err) break;
      @(negedge clk);
    end
    chk(nb_ok == 1'b1, "R7", "finished with busy ignored", int'(nb_ok), 1);
    chk(nb_wr == 4, "R7", "one write edge per byte", nb_wr, 4);
    begin
      int bad = 0;
      for (int i = 0; i < 4; i++) if (nb_rx[i] != 8'hA0 + 8'(i)) bad++;
      chk(bad == 0, "R7", "bytes mismatched", bad, 0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule